// File: doc/BRIEF.md
# Read Completion Splitter

This block takes one accepted memory read request, given as a start byte address and a byte length. It turns the request into a series of completion descriptors. Each descriptor gives the address at which a completion starts, the number of bytes it carries, and the number of bytes still owed to the request, counting that completion itself. A downstream agent fetches the data and builds the packets.

The splitting follows two configuration inputs. The completion boundary select chooses whether completions split on 64-byte or on 128-byte aligned addresses. The payload size code caps the payload of any single completion. Only the first completion may start off the boundary; every later one starts on an aligned address.

The block rejects a request of zero length and a request that crosses a 4 KB page. Such a request is accepted and answered with an error pulse and no descriptors. The block has no setting that limits the length of incoming requests, so any length up to a full page is served.

Top module: `cplSplitter`

## Requirements
- R1: After reset, descValid and reqErr are 0 and reqReady is 1.
- R2: reqReady is 1 only while no descriptor is pending, and a request is accepted on a cycle where reqValid and reqReady are both 1.
- R3: The first descriptor's address equals reqAddr. Each later address equals the previous address plus the previous count. No count is zero, and the counts add up to reqLen.
- R4: descRemain of the first descriptor equals reqLen. Each later descRemain is the previous descRemain minus the previous descCount. descLast is 1 exactly on the descriptor whose count equals its remaining count.
- R5: No descCount exceeds the payload limit. The limit is 128 << mpsCode for codes 0 to 5; codes 6 and 7 both mean 4096 bytes.
- R6: The boundary is 64 bytes when rcbSel is 0 and 128 bytes when rcbSel is 1. Every descriptor other than the last ends (address plus count) on a multiple of the boundary. With rcbSel 1, no split lands on an address that is a multiple of 64 but not of 128.
- R7: If the current address is not on a boundary, the count is the smaller of the distance to the next boundary and the remaining bytes. Otherwise it is the smaller of the payload limit and the remaining bytes.
- R8: A request with reqLen 0, or with (reqAddr mod 4096) + reqLen > 4096, raises reqErr for exactly one cycle, in the cycle after acceptance. It produces no descriptor, and reqReady stays 1.
- R9: Any non-zero length up to 4096 that stays within its 4 KB page is served without reqErr, whatever its size.
- R10: While descValid is 1 and descReady is 0, descValid, descAddr, descCount and descRemain hold their values into the next cycle.
- R11: In the cycle after the descriptor flagged by descLast is taken, reqReady is 1 and descValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A read request is offered |
| reqReady | output | 1 | The block can take a request |
| reqAddr | input | ADDR_W | Start byte address of the request |
| reqLen | input | LEN_W | Request length in bytes |
| rcbSel | input | 1 | Completion boundary: 0 means 64 bytes, 1 means 128 bytes |
| mpsCode | input | 3 | Payload size code: 128 << code, with codes 6 and 7 meaning 4096 |
| descValid | output | 1 | A descriptor is offered |
| descReady | input | 1 | The consumer takes the descriptor |
| descAddr | output | ADDR_W | Start address of this completion |
| descCount | output | LEN_W | Bytes carried by this completion |
| descRemain | output | LEN_W | Bytes still owed, including this completion |
| descLast | output | 1 | This is the final completion of the request |
| reqErr | output | 1 | One-cycle pulse: the accepted request was malformed |

## Verification
The assertions assume that rcbSel and mpsCode stay constant while a request is being split. They also assume that the consumer does not change descReady in a way that depends on values after the clock edge. The stimulus changes the configuration only at the point where reqReady is high, and it drives every input on the falling edge. The boundary and payload assertions further assume that a served request never leaves its 4 KB page. The bench relies on the block's own error check to keep such requests out, and it offers page-crossing requests deliberately so that the error path is exercised.

// File: rtl/cplSplitPkg.sv
package cplSplitPkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } splitState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture a good request
    logic step;  // a descriptor was taken
  } splitStrobe_t;
endpackage

// File: rtl/cplSplitPath.sv
module cplSplitPath #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 13
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cplSplitPkg::splitStrobe_t strobe,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [LEN_W-1:0]          reqLen,
  input  logic                      rcbSel,
  input  logic [2:0]                mpsCode,
  output logic                      reqBad,
  output logic [ADDR_W-1:0]         descAddr,
  output logic [LEN_W-1:0]          descCount,
  output logic [LEN_W-1:0]          descRemain,
  output logic                      descLast
);
  localparam int PAGE_BYTES = 4096;
  localparam int PAGE_BITS  = $clog2(PAGE_BYTES);
  localparam int MAX_CODE   = 5;

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remain;
  logic [LEN_W-1:0]  rcbBytes;
  logic [LEN_W-1:0]  mpsBytes;
  logic [LEN_W-1:0]  misalign;
  logic [LEN_W-1:0]  chunkLimit;
  logic [LEN_W:0]    endOffset;

  // request malformation: empty, or runs past its page
  always_comb begin
    endOffset = {1'b0, LEN_W'(reqAddr[PAGE_BITS-1:0])} + {1'b0, reqLen};
    reqBad    = (reqLen == '0) || (endOffset > (LEN_W+1)'(PAGE_BYTES));
  end

  // chunk sizing
  always_comb begin
    rcbBytes   = rcbSel ? LEN_W'(128) : LEN_W'(64);
    mpsBytes   = (int'(mpsCode) > MAX_CODE) ? LEN_W'(PAGE_BYTES)
                                            : (LEN_W'(128) << mpsCode);
    misalign   = curAddr[LEN_W-1:0] & (rcbBytes - LEN_W'(1));
    chunkLimit = (misalign != '0) ? (rcbBytes - misalign) : mpsBytes;
    descCount  = (remain < chunkLimit) ? remain : chunkLimit;
    descLast   = (descCount == remain);
    descAddr   = curAddr;
    descRemain = remain;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      remain  <= '0;
    end else if (strobe.load) begin
      curAddr <= reqAddr;
      remain  <= reqLen;
    end else if (strobe.step) begin
      curAddr <= curAddr + ADDR_W'(descCount);
      remain  <= remain - descCount;
    end
  end

  p_cnt_le_mps_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (descCount <= mpsBytes && descCount != '0));

  p_split_aligned_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !descLast) |=>
      ((curAddr[LEN_W-1:0] & (rcbBytes - LEN_W'(1))) == '0));
endmodule

// File: rtl/cplSplitCtrl.sv
module cplSplitCtrl (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqBad,
  input  logic                      descReady,
  input  logic                      descLast,
  output logic                      reqReady,
  output logic                      descValid,
  output logic                      reqErr,
  output cplSplitPkg::splitStrobe_t strobe
);
  import cplSplitPkg::*;

  splitState_t state, stateNext;
  logic        accept;

  always_comb begin
    reqReady    = (state == ST_IDLE);
    descValid   = (state == ST_BUSY);
    accept      = reqValid && reqReady;
    strobe.load = accept && !reqBad;
    strobe.step = descValid && descReady;
    stateNext   = state;
    case (state)
      ST_IDLE: if (strobe.load) stateNext = ST_BUSY;
      ST_BUSY: if (strobe.step && descLast) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      reqErr <= 1'b0;
    end else begin
      state  <= stateNext;
      reqErr <= accept && reqBad;
    end
  end

  p_err_no_desc_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> (!descValid && reqReady));

  p_ready_after_last_r11: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && descReady && descLast) |=> (reqReady && !descValid));
endmodule

// File: rtl/cplSplitter.sv
module cplSplitter #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              rcbSel,
  input  logic [2:0]        mpsCode,
  output logic              descValid,
  input  logic              descReady,
  output logic [ADDR_W-1:0] descAddr,
  output logic [LEN_W-1:0]  descCount,
  output logic [LEN_W-1:0]  descRemain,
  output logic              descLast,
  output logic              reqErr
);
  cplSplitPkg::splitStrobe_t strobe;
  logic reqBad;

  cplSplitCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBad(reqBad),
    .descReady(descReady), .descLast(descLast), .reqReady(reqReady),
    .descValid(descValid), .reqErr(reqErr), .strobe(strobe)
  );

  cplSplitPath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqLen(reqLen), .rcbSel(rcbSel), .mpsCode(mpsCode), .reqBad(reqBad),
    .descAddr(descAddr), .descCount(descCount), .descRemain(descRemain),
    .descLast(descLast)
  );

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && !descReady) |=>
      (descValid && $stable(descAddr) && $stable(descCount) && $stable(descRemain)));

  p_remain_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && descReady && !descLast) |=>
      (descValid && descRemain == $past(descRemain) - $past(descCount)));
endmodule

// File: tb/tb_cplSplitter.sv
module tb_cplSplitter;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic rcbSel = 1'b0;
  logic [2:0] mpsCode = '0;
  logic descReady = 1'b0;
  logic reqReady, descValid, descLast, reqErr;
  logic [ADDR_W-1:0] descAddr;
  logic [LEN_W-1:0] descCount, descRemain;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cplSplitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .rcbSel(rcbSel), .mpsCode(mpsCode),
    .descValid(descValid), .descReady(descReady), .descAddr(descAddr),
    .descCount(descCount), .descRemain(descRemain), .descLast(descLast),
    .reqErr(reqErr)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runReq(input int off, input int len, input bit rcb, input int code);
    int rb, mps, cur, rem, mis, lim, cnt, step, total;
    bit bad, done, stall;
    rb  = rcb ? 128 : 64;
    mps = (code > 5) ? 4096 : (128 << code);
    bad = (len == 0) || (off + len > 4096);
    @(negedge clk);
    rcbSel = rcb; mpsCode = 3'(code);
    reqAddr = 32'h1234_5000 + 32'(off); reqLen = LEN_W'(len); reqValid = 1'b1;
    chk(reqReady == 1'b1, "R2 ready when idle", reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0;
    if (bad) begin
      chk(reqErr == 1'b1 && descValid == 1'b0, "R8 error pulse", {reqErr, descValid}, 2);
      @(negedge clk);
      chk(reqErr == 1'b0 && descValid == 1'b0 && reqReady == 1'b1,
          "R8 single pulse, no descriptor", {reqErr, descValid, reqReady}, 1);
      return;
    end
    chk(reqErr == 1'b0, "R9 no size-limit error", reqErr, 0);
    cur = 32'h1234_5000 + off; rem = len; step = 0; total = 0; done = 0;
    while (!done && !finished) begin
      mis = cur % rb;
      lim = (mis != 0) ? (rb - mis) : mps;
      cnt = (rem < lim) ? rem : lim;
      chk(descValid == 1'b1 && reqReady == 1'b0, "R2 busy while descriptors pending",
          {descValid, reqReady}, 2);
      chk(descAddr == ADDR_W'(cur), "R3 address", descAddr, cur);
      chk(descCount == LEN_W'(cnt), "R7 count (R5 limit, R6 boundary)", descCount, cnt);
      chk(descRemain == LEN_W'(rem), "R4 remaining", descRemain, rem);
      chk(descLast == (cnt == rem), "R4 last flag", descLast, cnt == rem);
      chk(cnt <= mps, "R5 payload cap", cnt, mps);
      if (cnt != rem) chk(((cur + cnt) % rb) == 0, "R6 split on boundary", (cur + cnt) % rb, 0);
      stall = (step % 3 == 2);
      descReady = !stall;
      @(negedge clk);
      if (!stall) begin
        cur += cnt; rem -= cnt; total += cnt;
        done = (rem == 0);
      end else begin
        chk(descAddr == ADDR_W'(cur) && descCount == LEN_W'(cnt), "R10 hold under stall",
            descCount, cnt);
      end
      step++;
    end
    descReady = 1'b0;
    chk(total == len, "R3 counts sum to length", total, len);
    chk(reqReady == 1'b1 && descValid == 1'b0, "R11 ready after last", {reqReady, descValid}, 2);
  endtask

  initial begin
    int offs[9];
    int lens[10];
    offs = '{0, 3, 60, 64, 100, 128, 2048, 4032, 4095};
    lens = '{0, 1, 4, 63, 64, 65, 129, 512, 1000, 4096};
    repeat (3) @(negedge clk);
    chk(descValid == 1'b0 && reqErr == 1'b0 && reqReady == 1'b1, "R1 reset state",
        {descValid, reqErr, reqReady}, 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(descValid == 1'b0 && reqErr == 1'b0 && reqReady == 1'b1, "R1 after release",
        {descValid, reqErr, reqReady}, 1);
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 8; c++)
        foreach (offs[i])
          foreach (lens[j])
            runReq(offs[i], lens[j], r[0], c);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule